// File: doc/BRIEF.md
# Mask-Match Opcode Decoder with Cycle Ring

This block is the control decoder of a small 8-bit processor. A one-hot cycle ring (T1 through T7) advances once per clock, and a set of decode lines compares the opcode held in the instruction register with it. Each line has three conditions: a set of opcode bits that must be 1, a set that must be 0, and the cycle slots in which it may fire. A line fires only when all three hold. Several lines may fire in the same cycle, and the control outputs are the OR of every line that fires. The datapath reads these outputs to fetch operands and opcodes, advance the program counter, and load A, X or Y from the bus.

The line table in this block covers absolute loads (opcodes 0xAC to 0xAF) and conditional branches (any opcode with low five bits 10000). When a line ending an instruction fires, the ring returns to T1. At that same boundary a pending interrupt is acknowledged. A non-maskable request takes precedence over a maskable one. An opcode that no ending line matches lets the ring shift past T7 to all-zero. After that nothing fires, so no interrupt is ever acknowledged. Only reset recovers from this state.

Synchronous reset loads T1 and a one-cycle boot state. In the boot cycle the block asserts opcode fetch and instruction end, whatever the instruction register holds.

Top module: `opdec_top`

## Requirements
- R1: Without an instruction end, `tstate` shifts left by one position each clock: T1 is bit 0 and T7 is bit 6. It never holds more than one set bit.
- R2: In the clock after `instr_end` is high, `tstate` equals T1 (7'b0000001).
- R3: A ring shifted past T7 stays all-zero until reset. While it is all-zero, every control output, `irq_ack` and `nmi_ack` stay low.
- R4: While reset is held, and in the first cycle after it, `tstate` is T1. In that boot cycle only `fetch_opcode` and `instr_end` are asserted, whatever the value of `ir`.
- R5: When `ir[7:2]` = 101011, `fetch_operand` and `pc_inc` are high in T1 and in T2.
- R6: When `ir[7:2]` = 101011, T4 asserts `fetch_opcode`, `pc_inc` and `instr_end`.
- R7: In T3, `bus_to_y` is high only for `ir` = 0xAC. `bus_to_a` is high for 0xAD and 0xAF. `bus_to_x` is high for 0xAE and 0xAF.
- R8: When `ir[4:0]` = 10000 (a branch), T1 asserts `fetch_operand` and `pc_inc`. T2 asserts `fetch_opcode`, `pc_inc` and `instr_end`. In T2, `branch_take` is high when the flag chosen by `ir[7:6]` equals `ir[5]`. The flag choice is 00 = `flags[3]` (negative), 01 = `flags[2]` (overflow), 10 = `flags[1]` (carry), 11 = `flags[0]` (zero).
- R9: Lines that fire together merge their effects: opcode 0xAF asserts both `bus_to_a` and `bus_to_x` in the same T3 cycle.
- R10: `nmi_ack` equals `instr_end & nmi`. `irq_ack` equals `instr_end & irq & ~nmi`. Neither is high without `instr_end`.
- R11: An opcode that matches no line (for example 0x00) asserts no control output in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 8 | Current opcode from the instruction register |
| flags | input | 4 | Status flags {N, V, C, Z} |
| irq | input | 1 | Maskable interrupt request |
| nmi | input | 1 | Non-maskable interrupt request |
| tstate | output | 7 | One-hot cycle ring, bit 0 = T1 |
| fetch_opcode | output | 1 | Read next opcode from memory |
| fetch_operand | output | 1 | Read an operand byte from memory |
| pc_inc | output | 1 | Increment program counter |
| bus_to_a | output | 1 | Load accumulator from data bus |
| bus_to_x | output | 1 | Load X from data bus |
| bus_to_y | output | 1 | Load Y from data bus |
| branch_take | output | 1 | Branch condition met in the branch evaluation cycle |
| instr_end | output | 1 | Instruction ends; ring returns to T1 |
| irq_ack | output | 1 | Maskable interrupt accepted at this boundary |
| nmi_ack | output | 1 | Non-maskable interrupt accepted at this boundary |

## Verification
The assertions expect `ir` to change only at instruction boundaries, as it would when loaded by the opcode fetch. The ring and the decoded outputs are then consistent for a whole instruction. The random stimulus therefore picks a new opcode only after an end cycle, drawing from the load and branch families. Flags, `irq` and `nmi` may change freely on every cycle. Undefined opcodes are applied only in a directed sequence that runs into the locked state, and that sequence ends with a reset.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int T_W       = 7;
    localparam int OP_W      = 8;
    localparam int NUM_LINES = 7;

    typedef struct packed {
        logic fetch_op;
        logic fetch_arg;
        logic pc_inc;
        logic ld_a;
        logic ld_x;
        logic ld_y;
        logic br_eval;
        logic eoi;
    } ctrl_t;

    typedef struct packed {
        logic [OP_W-1:0] ones;
        logic [OP_W-1:0] zeros;
        logic [T_W-1:0]  slots;
        ctrl_t           ctrl;
    } line_t;

    localparam logic [T_W-1:0] SLOT_T1 = 7'b0000001;
    localparam logic [T_W-1:0] SLOT_T2 = 7'b0000010;
    localparam logic [T_W-1:0] SLOT_T3 = 7'b0000100;
    localparam logic [T_W-1:0] SLOT_T4 = 7'b0001000;

    localparam ctrl_t CTRL_NONE = '0;

    function automatic ctrl_t mk_ctrl(logic fo, logic fa, logic pi, logic la,
                                      logic lx, logic ly, logic be, logic eo);
        ctrl_t c;
        c.fetch_op  = fo;
        c.fetch_arg = fa;
        c.pc_inc    = pi;
        c.ld_a      = la;
        c.ld_x      = lx;
        c.ld_y      = ly;
        c.br_eval   = be;
        c.eoi       = eo;
        return c;
    endfunction

    // decode line table: required ones, required zeros, cycle slots, effect
    function automatic line_t line_at(int idx);
        line_t l;
        case (idx)
            0: l = '{8'hAC, 8'h50, SLOT_T1 | SLOT_T2, mk_ctrl(0, 1, 1, 0, 0, 0, 0, 0)};
            1: l = '{8'hAC, 8'h50, SLOT_T4,           mk_ctrl(1, 0, 1, 0, 0, 0, 0, 1)};
            2: l = '{8'hAC, 8'h53, SLOT_T3,           mk_ctrl(0, 0, 0, 0, 0, 1, 0, 0)};
            3: l = '{8'hAD, 8'h50, SLOT_T3,           mk_ctrl(0, 0, 0, 1, 0, 0, 0, 0)};
            4: l = '{8'hAE, 8'h50, SLOT_T3,           mk_ctrl(0, 0, 0, 0, 1, 0, 0, 0)};
            5: l = '{8'h10, 8'h0F, SLOT_T1,           mk_ctrl(0, 1, 1, 0, 0, 0, 0, 0)};
            6: l = '{8'h10, 8'h0F, SLOT_T2,           mk_ctrl(1, 0, 1, 0, 0, 0, 1, 1)};
            default: l = '{8'hFF, 8'hFF, '0, CTRL_NONE};
        endcase
        return l;
    endfunction

    localparam ctrl_t CTRL_BOOT = mk_ctrl(1, 0, 0, 0, 0, 0, 0, 1);

endpackage

// File: rtl/opdec_line.sv
module opdec_line #(
    parameter int            OPW   = 8,
    parameter int            TW    = 7,
    parameter logic [OPW-1:0] ONES  = '0,
    parameter logic [OPW-1:0] ZEROS = '0,
    parameter logic [TW-1:0]  SLOTS = '0
) (
    input  logic [OPW-1:0] ir,
    input  logic [TW-1:0]  tstate,
    output logic           hit
);
    logic ones_ok, zeros_ok, slot_ok;

    always_comb begin
        ones_ok  = ((ir & ONES) == ONES);
        zeros_ok = ((~ir & ZEROS) == ZEROS);
        slot_ok  = |(tstate & SLOTS);
        hit      = ones_ok & zeros_ok & slot_ok;
    end
endmodule

// File: rtl/opdec_ring.sv
module opdec_ring #(
    parameter int TW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eoi,
    output logic [TW-1:0] tstate,
    output logic          boot
);
    localparam logic [TW-1:0] FIRST = TW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tstate <= FIRST;
            boot   <= 1'b1;
        end else begin
            boot   <= 1'b0;
            tstate <= eoi ? FIRST : (tstate << 1);
        end
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tstate));

    p_shift_r1: assert property (@(posedge clk) disable iff (rst)
        (!eoi && tstate != '0) |=> (tstate == ($past(tstate) << 1)));

    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        eoi |=> (tstate == FIRST));

    p_stuck_r3: assert property (@(posedge clk) disable iff (rst)
        (tstate == '0) |=> (tstate == '0));
endmodule

// File: rtl/opdec_cond.sv
module opdec_cond (
    input  logic [7:0] ir,
    input  logic [3:0] flags,
    output logic       cond_true
);
    logic sel_flag;

    always_comb begin
        unique case (ir[7:6])
            2'b00:   sel_flag = flags[3];
            2'b01:   sel_flag = flags[2];
            2'b10:   sel_flag = flags[1];
            default: sel_flag = flags[0];
        endcase
        cond_true = (sel_flag == ir[5]);
    end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
    import opdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] ir,
    input  logic [3:0] flags,
    input  logic       irq,
    input  logic       nmi,
    output logic [6:0] tstate,
    output logic       fetch_opcode,
    output logic       fetch_operand,
    output logic       pc_inc,
    output logic       bus_to_a,
    output logic       bus_to_x,
    output logic       bus_to_y,
    output logic       branch_take,
    output logic       instr_end,
    output logic       irq_ack,
    output logic       nmi_ack
);
    logic [NUM_LINES-1:0] hits;
    logic                 boot;
    logic                 cond_true;
    ctrl_t                merged;
    ctrl_t                ctrl;

    opdec_ring #(.TW(T_W)) u_ring (
        .clk    (clk),
        .rst    (rst),
        .eoi    (ctrl.eoi),
        .tstate (tstate),
        .boot   (boot)
    );

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        localparam line_t L = line_at(gi);
        opdec_line #(
            .OPW   (OP_W),
            .TW    (T_W),
            .ONES  (L.ones),
            .ZEROS (L.zeros),
            .SLOTS (L.slots)
        ) u_line (
            .ir     (ir),
            .tstate (tstate),
            .hit    (hits[gi])
        );
    end

    opdec_cond u_cond (
        .ir        (ir),
        .flags     (flags),
        .cond_true (cond_true)
    );

    always_comb begin
        merged = CTRL_NONE;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (hits[i]) merged = merged | line_at(i).ctrl;
        end
        ctrl = boot ? CTRL_BOOT : merged;
    end

    assign fetch_opcode  = ctrl.fetch_op;
    assign fetch_operand = ctrl.fetch_arg;
    assign pc_inc        = ctrl.pc_inc;
    assign bus_to_a      = ctrl.ld_a;
    assign bus_to_x      = ctrl.ld_x;
    assign bus_to_y      = ctrl.ld_y;
    assign branch_take   = ctrl.br_eval & cond_true;
    assign instr_end     = ctrl.eoi;
    assign nmi_ack       = ctrl.eoi & nmi;
    assign irq_ack       = ctrl.eoi & irq & ~nmi;

    p_locked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (tstate == '0) |-> !(instr_end || irq_ack || nmi_ack || pc_inc || fetch_opcode));

    p_ack_at_end_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_ack || nmi_ack) |-> (instr_end && $onehot0({irq_ack, nmi_ack})));

    p_load_slot_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_to_a || bus_to_x || bus_to_y) |-> (tstate == 7'b0000100));

    p_boot_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(boot) |-> (tstate == 7'b0000001));
endmodule

// File: tb/opdec_top_tb.sv
module opdec_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ir = 8'h00;
    logic [3:0] flags = 4'h0;
    logic       irq = 1'b0;
    logic       nmi = 1'b0;
    logic [6:0] tstate;
    logic       fetch_opcode, fetch_operand, pc_inc, bus_to_a, bus_to_x, bus_to_y;
    logic       branch_take, instr_end, irq_ack, nmi_ack;

    int total = 0;
    int bad   = 0;
    logic [6:0] exp_t = 7'b0000001;
    logic       exp_boot = 1'b1;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opdec_top u_dut (
        .clk(clk), .rst(rst), .ir(ir), .flags(flags), .irq(irq), .nmi(nmi),
        .tstate(tstate), .fetch_opcode(fetch_opcode), .fetch_operand(fetch_operand),
        .pc_inc(pc_inc), .bus_to_a(bus_to_a), .bus_to_x(bus_to_x), .bus_to_y(bus_to_y),
        .branch_take(branch_take), .instr_end(instr_end), .irq_ack(irq_ack), .nmi_ack(nmi_ack)
    );

    // {fetch_op, fetch_arg, pc_inc, ld_a, ld_x, ld_y, take, end}
    function automatic logic [7:0] model(logic [7:0] op, logic [6:0] t, logic bt, logic [3:0] f);
        logic [7:0] v = '0;
        logic fl;
        if (bt) return 8'b1000_0001;
        if (op[7:2] == 6'b101011) begin
            if (t == 7'd1 || t == 7'd2) begin v[6] = 1; v[5] = 1; end
            if (t == 7'd4) begin v[4] = op[0]; v[3] = op[1]; v[2] = (op == 8'hAC); end
            if (t == 7'd8) begin v[7] = 1; v[5] = 1; v[0] = 1; end
        end
        if (op[4:0] == 5'b10000) begin
            fl = (op[7:6] == 2'd0) ? f[3] : (op[7:6] == 2'd1) ? f[2] :
                 (op[7:6] == 2'd2) ? f[1] : f[0];
            if (t == 7'd1) begin v[6] = 1; v[5] = 1; end
            if (t == 7'd2) begin v[7] = 1; v[5] = 1; v[0] = 1; v[1] = (fl == op[5]); end
        end
        return v;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag);
        logic [7:0] e;
        logic [7:0] a;
        #1;
        e = model(ir, exp_t, exp_boot, flags);
        a = {fetch_opcode, fetch_operand, pc_inc, bus_to_a, bus_to_x, bus_to_y, branch_take, instr_end};
        check(tag, {8'h0, a}, {8'h0, e});
        check("R1", {9'h0, tstate}, {9'h0, exp_t});
        check("R10", {14'h0, nmi_ack, irq_ack}, {14'h0, e[0] & nmi, e[0] & irq & ~nmi});
        @(posedge clk);
        if (rst) begin exp_t = 7'd1; exp_boot = 1; end
        else begin exp_t = e[0] ? 7'd1 : (exp_t << 1); exp_boot = 0; end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; irq = 0; nmi = 0;
        @(posedge clk); @(negedge clk);
        exp_t = 7'd1; exp_boot = 1;
        step("R4");
        rst = 0;
        step("R4");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        ir = 8'hAF;
        do_reset();

        // R9 / R7: 0xAF merges A and X loads in T3
        ir = 8'hAF;
        step("R5"); step("R5");
        #1;
        check("R9", {14'h0, bus_to_a, bus_to_x}, 16'h3);
        step("R7"); step("R6");

        // R11 / R3: no matching line, ring runs out, interrupts blocked
        ir = 8'h00; irq = 1; nmi = 0;
        for (int k = 0; k < 7; k++) step("R11");
        #1;
        check("R3", {9'h0, tstate}, 16'h0);
        nmi = 1;
        for (int k = 0; k < 4; k++) step("R3");
        do_reset();

        // random instruction stream
        for (int n = 0; n < 600; n++) begin
            logic [2:0] r = 3'($urandom);
            string tg;
            if (r < 4) ir = 8'hAC + 8'(r);
            else ir = {2'($urandom), 1'($urandom), 5'b10000};
            tg = (ir[4:0] == 5'b10000) ? "R8" : "R7";
            do begin
                flags = 4'($urandom);
                irq = 1'($urandom);
                nmi = (($urandom % 4) == 0);
                step(exp_t == 7'd1 ? "R2" : tg);
            end while (exp_t != 7'd1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule